// File: doc/BRIEF.md
# Serial and Pin Mode Control Receiver

This block chooses the operating mode of a stereo processing path. A host can set the mode in two ways. It can drive three level pins directly. It can also shift a four-bit control word over a three-wire link made of data, clock and strobe. The word is first shifted into a holding register. It takes effect only when a strobe pulse copies it into the active register. A select pin decides whether the pins or the active register control the path.

All asynchronous inputs are synchronised to the system clock. Edges of the serial clock and the strobe are found in that clock domain. A serial clock rise is rejected if the low phase before it was too short. A strobe is rejected if its high phase was too short.

The chosen control set is turned into registered enables and a mode code:
- pass-through
- wider enhancement
- mute
- sleep

Sleep can only be reached through the serial word, and it always implies mute.

Top module: `mode_ctl_rx`

## Requirements
- R1: After reset every enable is 0 and the mode code is 0. The active register reads as all zeros, which means the lower enhancement level, unmuted.
- R2: On each accepted serial clock rise, the data line is shifted in. The word is sent with pass-through first, then wide, then mute, then sleep. After four bits, word `{b0,b1,b2,b3}` in send order means thru=b0, wide=b1, quiet=b2, sleep=b3.
- R3: Shifting bits changes no output. The shifted contents reach the active register only on the falling edge of a valid strobe.
- R4: With `host_sel_i`=1 the controls come from the pins `pin_thru_i`, `pin_wide_i` and `pin_quiet_i`, and sleep always reads as 0.
- R5: Sleep=1 forces the mute enable to 1 whatever the mute bit says. The mode code is then 4, and both the quiet and sleep enables are 1.
- R6: Mute=1 without sleep gives mode code 3 and only the quiet enable, whatever thru and wide are.
- R7: With mute=0 and thru=1 the mode code is 2 and only the pass-through enable is set. The wide bit is ignored.
- R8: With mute=0 and thru=0 the mode code depends on the wide bit:
  - wide=0 gives code 0 with no enable (lower level).
  - wide=1 gives code 1 with only the wide enable (higher level).
- R9: A strobe whose synchronised high phase is shorter than `MIN_STB_CYC` system cycles commits nothing.
- R10: A serial clock rise that follows a synchronised low phase shorter than `MIN_CLK_LO` cycles shifts nothing.
- R11: A strobe after fewer than four shifted bits commits the holding register as it stands.
- R12: The active register keeps its contents while pin control is selected. Returning to serial control restores the mode it encodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_dat_i | input | 1 | Serial data |
| ser_stb_i | input | 1 | Serial commit strobe |
| host_sel_i | input | 1 | 1: pin control, 0: serial register control |
| pin_thru_i | input | 1 | Pin request for pass-through |
| pin_wide_i | input | 1 | Pin request for the higher enhancement level |
| pin_quiet_i | input | 1 | Pin request for mute |
| thru_en_o | output | 1 | Pass-through selected |
| wide_en_o | output | 1 | Higher enhancement level selected |
| quiet_en_o | output | 1 | Outputs muted |
| sleep_en_o | output | 1 | Power-save active |
| mode_o | output | 3 | Mode code: 0 lower, 1 higher, 2 pass, 3 mute, 4 sleep |

## Verification
The assertions assume the following about the inputs:
- The system clock runs at least four times faster than the serial clock.
- Each serial level is held for several system cycles, so a synchronised edge is seen once.
- The strobe does not overlap the serial clock edges.

The stimulus changes inputs only on the falling system clock edge. It holds every serial clock phase for four cycles and every strobe for four cycles. The only exceptions are the deliberate one-cycle glitch and the one-cycle short strobe. The bench waits eight cycles before each output check, which covers the synchroniser, edge detect, commit and output register stages.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef struct packed {
    logic thru;
    logic wide;
    logic quiet;
    logic sleep;
  } ctl_t;

  typedef enum logic [2:0] {
    MODE_LOW   = 3'd0,
    MODE_HIGH  = 3'd1,
    MODE_PASS  = 3'd2,
    MODE_MUTE  = 3'd3,
    MODE_SLEEP = 3'd4
  } mode_e;
endpackage

// File: rtl/mc_sync.sv
module mc_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/mc_serial_rx.sv
module mc_serial_rx #(
  parameter int WORD_W      = 4,
  parameter int MIN_CLK_LO  = 2,
  parameter int MIN_STB_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              stb_s,
  output logic [WORD_W-1:0] word_o
);
  localparam int LO_W = $clog2(MIN_CLK_LO + 1);
  localparam int HI_W = $clog2(MIN_STB_CYC + 1);

  logic              scl_q, stb_q;
  logic [LO_W-1:0]   lo_cnt_q, lo_cnt_d;
  logic [HI_W-1:0]   hi_cnt_q, hi_cnt_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [WORD_W-1:0] active_q, active_d;
  logic              scl_rise, stb_fall, shift_ok, commit_ok;

  assign scl_rise  = scl_s & ~scl_q;
  assign stb_fall  = ~stb_s & stb_q;
  assign shift_ok  = scl_rise && (int'(lo_cnt_q) >= MIN_CLK_LO);
  assign commit_ok = stb_fall && (int'(hi_cnt_q) >= MIN_STB_CYC);

  always_comb begin
    lo_cnt_d = lo_cnt_q;
    if (scl_s) lo_cnt_d = '0;
    else if (int'(lo_cnt_q) < MIN_CLK_LO) lo_cnt_d = lo_cnt_q + 1'b1;

    hi_cnt_d = hi_cnt_q;
    if (stb_s) begin
      if (int'(hi_cnt_q) < MIN_STB_CYC) hi_cnt_d = hi_cnt_q + 1'b1;
    end else if (!stb_q) begin
      hi_cnt_d = '0;
    end

    shreg_d  = shreg_q;
    if (shift_ok) shreg_d = {shreg_q[WORD_W-2:0], sda_s};

    active_d = active_q;
    if (commit_ok) active_d = shreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b0;
      stb_q    <= 1'b0;
      lo_cnt_q <= '0;
      hi_cnt_q <= '0;
      shreg_q  <= '0;
      active_q <= '0;
    end else begin
      scl_q    <= scl_s;
      stb_q    <= stb_s;
      lo_cnt_q <= lo_cnt_d;
      hi_cnt_q <= hi_cnt_d;
      shreg_q  <= shreg_d;
      active_q <= active_d;
    end
  end

  assign word_o = active_q;

  assert_commit_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_q) |-> $past(stb_fall));
  assert_short_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && int'(hi_cnt_q) < MIN_STB_CYC) |=> $stable(active_q));
  assert_short_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && int'(lo_cnt_q) < MIN_CLK_LO) |=> $stable(shreg_q));
endmodule

// File: rtl/mc_mode_dec.sv
module mc_mode_dec
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_mode,
  input  logic [2:0] pins,
  input  ctl_t       ser_word,
  output logic       thru_en,
  output logic       wide_en,
  output logic       quiet_en,
  output logic       sleep_en,
  output logic [2:0] mode
);
  ctl_t  src;
  logic  muted;
  logic  thru_d, wide_d, quiet_d, sleep_d;
  mode_e mode_d;

  always_comb begin
    if (pin_mode) src = '{thru: pins[2], wide: pins[1], quiet: pins[0], sleep: 1'b0};
    else          src = ser_word;
    muted   = src.quiet | src.sleep;
    sleep_d = src.sleep;
    quiet_d = muted;
    thru_d  = ~muted & src.thru;
    wide_d  = ~muted & ~src.thru & src.wide;
    if (src.sleep)     mode_d = MODE_SLEEP;
    else if (muted)    mode_d = MODE_MUTE;
    else if (src.thru) mode_d = MODE_PASS;
    else if (src.wide) mode_d = MODE_HIGH;
    else               mode_d = MODE_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thru_en  <= 1'b0;
      wide_en  <= 1'b0;
      quiet_en <= 1'b0;
      sleep_en <= 1'b0;
      mode     <= 3'd0;
    end else begin
      thru_en  <= thru_d;
      wide_en  <= wide_d;
      quiet_en <= quiet_d;
      sleep_en <= sleep_d;
      mode     <= mode_d;
    end
  end

  assert_sleep_mutes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_en |-> quiet_en);
  assert_one_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({thru_en, wide_en, quiet_en}));
  assert_pins_no_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mode |=> !sleep_en);
endmodule

// File: rtl/mode_ctl_rx.sv
module mode_ctl_rx
  import mc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 4,
  parameter int MIN_CLK_LO  = 2,
  parameter int MIN_STB_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk_i,
  input  logic       ser_dat_i,
  input  logic       ser_stb_i,
  input  logic       host_sel_i,
  input  logic       pin_thru_i,
  input  logic       pin_wide_i,
  input  logic       pin_quiet_i,
  output logic       thru_en_o,
  output logic       wide_en_o,
  output logic       quiet_en_o,
  output logic       sleep_en_o,
  output logic [2:0] mode_o
);
  localparam int N_ASYNC = 7;

  logic [1:0]         rst_q;
  logic               rst_sn;
  logic [N_ASYNC-1:0] raw, synced;
  logic [WORD_W-1:0]  word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  assign raw = {ser_clk_i, ser_dat_i, ser_stb_i, host_sel_i,
                pin_thru_i, pin_wide_i, pin_quiet_i};

  mc_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_sn), .async_i(raw), .sync_o(synced));

  mc_serial_rx #(.WORD_W(WORD_W), .MIN_CLK_LO(MIN_CLK_LO),
                 .MIN_STB_CYC(MIN_STB_CYC)) ser_i (
    .clk(clk), .rst_n(rst_sn), .scl_s(synced[6]), .sda_s(synced[5]),
    .stb_s(synced[4]), .word_o(word));

  mc_mode_dec dec_i (
    .clk(clk), .rst_n(rst_sn), .pin_mode(synced[3]), .pins(synced[2:0]),
    .ser_word(ctl_t'(word[3:0])), .thru_en(thru_en_o), .wide_en(wide_en_o),
    .quiet_en(quiet_en_o), .sleep_en(sleep_en_o), .mode(mode_o));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_sn |=> (mode_o == 3'd0));
endmodule

// File: tb/mode_ctl_rx_tb_top.sv
module mode_ctl_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda, stb, sel, p_thru, p_wide, p_quiet;
  logic thru_en, wide_en, quiet_en, sleep_en;
  logic [2:0] mode;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mode_ctl_rx dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(scl), .ser_dat_i(sda), .ser_stb_i(stb),
    .host_sel_i(sel), .pin_thru_i(p_thru), .pin_wide_i(p_wide), .pin_quiet_i(p_quiet),
    .thru_en_o(thru_en), .wide_en_o(wide_en), .quiet_en_o(quiet_en),
    .sleep_en_o(sleep_en), .mode_o(mode));

  // Vector: {sel, pins thru/wide/quiet, word in send order, expected mode}
  localparam logic [10:0] VEC [14] = '{
    {1'b0, 3'b000, 4'b0000, 3'd0}, {1'b0, 3'b000, 4'b0100, 3'd1},
    {1'b0, 3'b000, 4'b1000, 3'd2}, {1'b0, 3'b000, 4'b1100, 3'd2},
    {1'b0, 3'b000, 4'b0010, 3'd3}, {1'b0, 3'b000, 4'b1110, 3'd3},
    {1'b0, 3'b000, 4'b0001, 3'd4}, {1'b0, 3'b000, 4'b1011, 3'd4},
    {1'b1, 3'b000, 4'b0000, 3'd0}, {1'b1, 3'b010, 4'b0000, 3'd1},
    {1'b1, 3'b100, 4'b0000, 3'd2}, {1'b1, 3'b110, 4'b0000, 3'd2},
    {1'b1, 3'b001, 4'b0000, 3'd3}, {1'b1, 3'b111, 4'b0000, 3'd3}};

  function automatic logic [3:0] en_of(input logic [2:0] m);
    case (m)
      3'd1:    en_of = 4'b0100;
      3'd2:    en_of = 4'b1000;
      3'd3:    en_of = 4'b0010;
      3'd4:    en_of = 4'b0011;
      default: en_of = 4'b0000;
    endcase
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] exp_mode);
    logic [3:0] got, exp_en;
    got = {thru_en, wide_en, quiet_en, sleep_en};
    exp_en = en_of(exp_mode);
    total++;
    if (mode !== exp_mode || got !== exp_en) begin
      fails++;
      $display("FAIL %s: mode=%0d en=%b expected mode=%0d en=%b",
               req, mode, got, exp_mode, exp_en);
    end
  endtask

  task automatic send_bits(input logic [3:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sda = bits[i]; scl = 1'b0; cyc(4);
      scl = 1'b1; cyc(4);
    end
    scl = 1'b0; cyc(2);
  endtask

  task automatic strobe(input int width);
    stb = 1'b1; cyc(width);
    stb = 1'b0; cyc(8);
  endtask

  initial begin
    rst_n = 1'b0; scl = 0; sda = 0; stb = 0; sel = 0;
    p_thru = 0; p_wide = 0; p_quiet = 0;
    cyc(5);
    rst_n = 1'b1;
    cyc(8);
    check("R1 reset", 3'd0);

    for (int v = 0; v < 14; v++) begin
      if (VEC[v][10]) begin
        {p_thru, p_wide, p_quiet} = VEC[v][9:7];
        sel = 1'b1; cyc(8);
        check("R4 pin control", VEC[v][2:0]);
      end else begin
        sel = 1'b0; cyc(4);
        send_bits(VEC[v][6:3], 4);
        strobe(4);
        case (VEC[v][2:0])
          3'd4:    check("R5 sleep forces mute (R2 order)", VEC[v][2:0]);
          3'd3:    check("R6 mute dominates (R2 order)", VEC[v][2:0]);
          3'd2:    check("R7 pass-through (R2 order)", VEC[v][2:0]);
          default: check("R8 level select (R2 order)", VEC[v][2:0]);
        endcase
      end
    end
    {p_thru, p_wide, p_quiet} = 3'b000;
    sel = 1'b0; cyc(8);
    check("R12 serial word kept across pin mode", 3'd4);

    // R3: shifting alone changes nothing
    send_bits(4'b0010, 4);
    cyc(8);
    check("R3 no change before strobe", 3'd4);
    strobe(4);
    check("R3 commit on strobe", 3'd3);

    // R9: short strobe ignored
    send_bits(4'b1000, 4);
    strobe(1);
    check("R9 short strobe", 3'd3);
    strobe(4);
    check("R9 valid strobe after short one", 3'd2);

    // R10: clock rise after a one-cycle low is not shifted
    send_bits(4'b0100, 3);
    sda = 1'b0; scl = 1'b0; cyc(4);
    scl = 1'b1; cyc(3);
    sda = 1'b1; scl = 1'b0; cyc(1);
    scl = 1'b1; cyc(3);
    scl = 1'b0; cyc(2);
    strobe(4);
    check("R10 glitch rejected", 3'd2);

    // R12: pins take over, serial returns
    {p_thru, p_wide, p_quiet} = 3'b001;
    sel = 1'b1; cyc(8);
    check("R12 pins override", 3'd3);
    sel = 1'b0; cyc(8);
    check("R12 serial restored", 3'd2);

    // R11: partial word after reset
    rst_n = 1'b0; cyc(3);
    rst_n = 1'b1; cyc(8);
    check("R1 reset mid-run", 3'd0);
    send_bits(4'b0011, 2);
    strobe(4);
    check("R11 partial word", 3'd4);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule